// File: doc/BRIEF.md
# Capability-Offset Address Translation Bypass

This unit sits in the execute stage of a load/store pipeline. It sits next to the normal TLB request path. Each memory request carries a 39-bit virtual address from the address adder. It also carries the metadata of the pointer that formed it: a lower and an upper bound, three permission bits, and a 16-bit translation offset with a flag that says whether the offset is in use. When the flag is set, the unit does no TLB lookup. It adds the offset to the top page-number field of the virtual address and keeps the two lower page-number fields and the 12-bit page offset unchanged. In the same cycle it checks the whole access span against the pointer's bounds and the permission the operation needs. A registered result appears one cycle later.

When the flag is clear, the request passes untouched to the TLB request port. The requester's ready signal follows the TLB port's ready, so no request is lost.

A separate fence input models a TLB flush request. The flush is passed on only when the fence's operand does not use the offset. Otherwise the fence does nothing.

Top module: `capoff_xlate_unit`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `rsp_valid` and `tlb_flush` are low.
- R2: A request with `req_valid` and `req_xoff_vld` both high is accepted in that cycle. Exactly one cycle later `rsp_valid` is high. If there is no fault, `rsp_paddr[43:30]` equals `req_vaddr[38:30]` zero-extended plus `req_xoff`.
- R3: On a fault-free response, `rsp_paddr[29:0]` equals the accepted `req_vaddr[29:0]`. These are the two lower 9-bit page-number fields and the 12-bit page offset.
- R4: The access span is the address up to address + bytes − 1. `req_size` codes 0, 1, 2 and 3 give 1, 2, 4 and 8 bytes. The span passes only when `req_lo` ≤ address and address + bytes ≤ `req_hi`, with both bounds 40 bits wide. Otherwise `rsp_cause` = 2.
- R5: `req_op` 0 is a load and needs `req_perm[0]` (read). Op 1 is a store and needs `req_perm[1]` (write). Op 2 is a fetch and needs `req_perm[2]` (execute). Op 3 never has permission. A missing permission gives `rsp_cause` = 1.
- R6: If the page-number sum is 16384 or more, so that it does not fit the 14-bit physical field of the 44-bit physical address, `rsp_cause` = 3.
- R7: When several faults apply, the permission fault wins over the bounds fault, and the bounds fault wins over the overflow fault. `rsp_exc` is high exactly when `rsp_cause` is non-zero. On any fault `rsp_paddr` is all zeros, so the access is not issued.
- R8: A request with `req_xoff_vld` low drives `tlb_req_valid` in the same cycle and copies the address, op and size unchanged. `req_ready` equals `tlb_req_ready`. Such a request produces no `rsp_valid`.
- R9: While `req_xoff_vld` is high, `req_ready` is high and `tlb_req_valid` is low.
- R10: `tlb_flush` pulses one cycle after `fence_valid` is high with `fence_xoff_vld` low. When `fence_xoff_vld` is high the fence causes no flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_vaddr | input | 39 | Virtual address |
| req_op | input | 2 | 0 load, 1 store, 2 fetch, 3 reserved |
| req_size | input | 2 | Access size code (1 << code bytes) |
| req_perm | input | 3 | Permissions: bit0 read, bit1 write, bit2 execute |
| req_lo | input | 40 | Lower bound, inclusive |
| req_hi | input | 40 | Upper bound, exclusive |
| req_xoff | input | 16 | Translation offset |
| req_xoff_vld | input | 1 | Offset in use (bypass) |
| fence_valid | input | 1 | TLB flush request |
| fence_xoff_vld | input | 1 | Flush operand uses an offset |
| rsp_valid | output | 1 | Bypass result valid |
| rsp_paddr | output | 44 | Physical address (zero on fault) |
| rsp_exc | output | 1 | Fault raised |
| rsp_cause | output | 2 | 0 none, 1 permission, 2 bounds, 3 overflow |
| tlb_req_valid | output | 1 | Request to the TLB port |
| tlb_req_ready | input | 1 | TLB port accepts |
| tlb_req_vaddr | output | 39 | Forwarded virtual address |
| tlb_req_op | output | 2 | Forwarded op |
| tlb_req_size | output | 2 | Forwarded size code |
| tlb_flush | output | 1 | Flush pulse to the TLB |

## Verification
The bench probes the span edges of the bounds check: an access that ends exactly at the upper bound, one that runs a single byte past it, and one that starts a byte below the lower bound. A design that compares only the start address, or uses ≤ where < belongs, lets the overrun through.

It places the page-number sum at 16383 and at 16384. A design that drops the carry or sizes the sum to the field width then wraps silently to a low physical page.

It crosses each op code with each missing permission, and stacks faults to expose a wrong priority or a non-zero address on a fault.

It holds the TLB port's ready low under pending requests and sends fences with and without the offset. A design that drops stalled requests or flushes on every fence is caught there.

// File: rtl/capx_pkg.sv
`timescale 1ns/1ps
package capx_pkg;

    localparam int VA_W     = 39;
    localparam int PGOFF_W  = 12;
    localparam int VPN_W    = 9;
    localparam int XOFF_W   = 16;
    localparam int PA_W     = 44;
    localparam int PERM_W   = 3;

    localparam int BND_W    = VA_W + 1;
    localparam int KEEP_W   = PGOFF_W + 2 * VPN_W;
    localparam int PPN2_W   = PA_W - KEEP_W;
    localparam int SUM_W    = ((XOFF_W > VPN_W) ? XOFF_W : VPN_W) + 1;

    localparam int PERM_RD  = 0;
    localparam int PERM_WR  = 1;
    localparam int PERM_EX  = 2;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_FETCH = 2'd2,
        OP_RSVD  = 2'd3
    } mem_op_e;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'd0,
        CAUSE_PERM   = 2'd1,
        CAUSE_BOUNDS = 2'd2,
        CAUSE_PAOVF  = 2'd3
    } fault_e;

    typedef struct packed {
        logic             vld;
        logic [PA_W-1:0]  paddr;
        fault_e           cause;
    } xlate_rsp_t;

    function automatic logic [3:0] size_to_bytes(input logic [1:0] code);
        return 4'd1 << code;
    endfunction

    function automatic logic perm_granted(input mem_op_e op, input logic [PERM_W-1:0] perm);
        case (op)
            OP_LOAD:  return perm[PERM_RD];
            OP_STORE: return perm[PERM_WR];
            OP_FETCH: return perm[PERM_EX];
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/capx_remap.sv
`timescale 1ns/1ps
module capx_remap
    import capx_pkg::*;
(
    input  logic [VA_W-1:0]   vaddr,
    input  logic [XOFF_W-1:0] xoff,
    output logic [PA_W-1:0]   paddr,
    output logic              pa_ovf
);
    logic [SUM_W-1:0] ppn_sum;

    assign ppn_sum = SUM_W'(vaddr[VA_W-1:KEEP_W]) + SUM_W'(xoff);

    generate
        if (SUM_W > PPN2_W) begin : g_narrow_pa
            assign pa_ovf = |ppn_sum[SUM_W-1:PPN2_W];
            assign paddr  = {ppn_sum[PPN2_W-1:0], vaddr[KEEP_W-1:0]};
        end else begin : g_wide_pa
            assign pa_ovf = 1'b0;
            assign paddr  = {PPN2_W'(ppn_sum), vaddr[KEEP_W-1:0]};
        end
    endgenerate
endmodule

// File: rtl/capx_guard.sv
`timescale 1ns/1ps
module capx_guard
    import capx_pkg::*;
(
    input  logic [VA_W-1:0]   vaddr,
    input  logic [1:0]        size,
    input  mem_op_e           op,
    input  logic [PERM_W-1:0] perm,
    input  logic [BND_W-1:0]  lo_bnd,
    input  logic [BND_W-1:0]  hi_bnd,
    output logic              perm_ok,
    output logic              range_ok
);
    logic [BND_W-1:0] span_first;
    logic [BND_W-1:0] span_end;

    always_comb begin
        span_first = BND_W'(vaddr);
        span_end   = span_first + BND_W'(size_to_bytes(size));
        range_ok   = (lo_bnd <= span_first) && (span_end <= hi_bnd);
        perm_ok    = perm_granted(op, perm);
    end
endmodule

// File: rtl/capx_resolve.sv
`timescale 1ns/1ps
module capx_resolve
    import capx_pkg::*;
(
    input  logic            perm_ok,
    input  logic            range_ok,
    input  logic            pa_ovf,
    input  logic [PA_W-1:0] paddr_raw,
    output fault_e          cause,
    output logic [PA_W-1:0] paddr_out
);
    always_comb begin
        if (!perm_ok)       cause = CAUSE_PERM;
        else if (!range_ok) cause = CAUSE_BOUNDS;
        else if (pa_ovf)    cause = CAUSE_PAOVF;
        else                cause = CAUSE_NONE;
        paddr_out = (cause == CAUSE_NONE) ? paddr_raw : '0;
    end
endmodule

// File: rtl/capoff_xlate_unit.sv
`timescale 1ns/1ps
module capoff_xlate_unit
    import capx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [1:0]        req_op,
    input  logic [1:0]        req_size,
    input  logic [PERM_W-1:0] req_perm,
    input  logic [BND_W-1:0]  req_lo,
    input  logic [BND_W-1:0]  req_hi,
    input  logic [XOFF_W-1:0] req_xoff,
    input  logic              req_xoff_vld,
    input  logic              fence_valid,
    input  logic              fence_xoff_vld,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic              rsp_exc,
    output logic [1:0]        rsp_cause,
    output logic              tlb_req_valid,
    input  logic              tlb_req_ready,
    output logic [VA_W-1:0]   tlb_req_vaddr,
    output logic [1:0]        tlb_req_op,
    output logic [1:0]        tlb_req_size,
    output logic              tlb_flush
);
    mem_op_e         op_e;
    logic [PA_W-1:0] paddr_raw;
    logic [PA_W-1:0] paddr_fin;
    logic            pa_ovf;
    logic            perm_ok;
    logic            range_ok;
    fault_e          cause_now;
    logic            bypass_take;
    xlate_rsp_t      rsp_q;
    logic            flush_q;

    assign op_e = mem_op_e'(req_op);

    capx_remap u_remap (
        .vaddr  (req_vaddr),
        .xoff   (req_xoff),
        .paddr  (paddr_raw),
        .pa_ovf (pa_ovf)
    );

    capx_guard u_guard (
        .vaddr    (req_vaddr),
        .size     (req_size),
        .op       (op_e),
        .perm     (req_perm),
        .lo_bnd   (req_lo),
        .hi_bnd   (req_hi),
        .perm_ok  (perm_ok),
        .range_ok (range_ok)
    );

    capx_resolve u_resolve (
        .perm_ok   (perm_ok),
        .range_ok  (range_ok),
        .pa_ovf    (pa_ovf),
        .paddr_raw (paddr_raw),
        .cause     (cause_now),
        .paddr_out (paddr_fin)
    );

    // Legacy path: straight through to the TLB port, stall follows its ready
    assign bypass_take   = req_valid && req_xoff_vld;
    assign tlb_req_valid = req_valid && !req_xoff_vld;
    assign tlb_req_vaddr = req_vaddr;
    assign tlb_req_op    = req_op;
    assign tlb_req_size  = req_size;
    assign req_ready     = req_xoff_vld ? 1'b1 : tlb_req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q   <= '0;
            flush_q <= 1'b0;
        end else begin
            rsp_q.vld <= bypass_take;
            if (bypass_take) begin
                rsp_q.paddr <= paddr_fin;
                rsp_q.cause <= cause_now;
            end
            flush_q <= fence_valid && !fence_xoff_vld;
        end
    end

    assign rsp_valid = rsp_q.vld;
    assign rsp_paddr = rsp_q.paddr;
    assign rsp_cause = rsp_q.cause;
    assign rsp_exc   = rsp_q.vld && (rsp_q.cause != CAUSE_NONE);
    assign tlb_flush = flush_q;
endmodule

// File: rtl/capx_chk.sv
`timescale 1ns/1ps
module capx_chk
    import capx_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic            req_ready,
    input logic [VA_W-1:0] req_vaddr,
    input logic            req_xoff_vld,
    input logic            rsp_valid,
    input logic [PA_W-1:0] rsp_paddr,
    input logic            rsp_exc,
    input logic            tlb_req_valid,
    input logic            tlb_req_ready,
    input logic            fence_valid,
    input logic            fence_xoff_vld,
    input logic            tlb_flush
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!rsp_valid && !tlb_flush));

    // R2
    rsp_origin_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid && req_xoff_vld));

    // R3
    low_fields_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_exc) |-> (rsp_paddr[KEEP_W-1:0] == $past(req_vaddr[KEEP_W-1:0])));

    // R7
    fault_no_issue_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_exc) |-> (rsp_paddr == '0));

    // R8
    no_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_xoff_vld && !tlb_req_ready) |-> !req_ready);

    // R9
    bypass_no_tlb_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_xoff_vld) |-> (req_ready && !tlb_req_valid));

    // R10
    flush_cause_chk: assert property (@(posedge clk) disable iff (rst)
        tlb_flush |-> $past(fence_valid && !fence_xoff_vld));

    // R10
    fence_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (fence_valid && fence_xoff_vld) |=> !tlb_flush);
endmodule

bind capoff_xlate_unit capx_chk u_chk (.*);

// File: tb/tb_capoff_xlate_unit.sv
`timescale 1ns/1ps
module tb_capoff_xlate_unit;
    import capx_pkg::*;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst;
    logic              req_valid;
    logic              req_ready;
    logic [VA_W-1:0]   req_vaddr;
    logic [1:0]        req_op;
    logic [1:0]        req_size;
    logic [PERM_W-1:0] req_perm;
    logic [BND_W-1:0]  req_lo;
    logic [BND_W-1:0]  req_hi;
    logic [XOFF_W-1:0] req_xoff;
    logic              req_xoff_vld;
    logic              fence_valid;
    logic              fence_xoff_vld;
    logic              rsp_valid;
    logic [PA_W-1:0]   rsp_paddr;
    logic              rsp_exc;
    logic [1:0]        rsp_cause;
    logic              tlb_req_valid;
    logic              tlb_req_ready;
    logic [VA_W-1:0]   tlb_req_vaddr;
    logic [1:0]        tlb_req_op;
    logic [1:0]        tlb_req_size;
    logic              tlb_flush;

    capoff_xlate_unit dut (.*);

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  finished = 0;

    bit     e_rv;
    bit     e_fl;
    int     e_cause;
    longint e_pa;

    task automatic chk(input string tag, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic void ref_xlate(input longint va, input int op, input int sz, input int perm,
                                      input longint lo, input longint hi, input int off,
                                      output int cause, output longint pa);
        longint vpn2  = va >> 30;
        longint sum   = vpn2 + longint'(off);
        longint bytes = longint'(1) << sz;
        bit     pok;
        case (op)
            0: pok = (perm & 1) != 0;
            1: pok = (perm & 2) != 0;
            2: pok = (perm & 4) != 0;
            default: pok = 0;
        endcase
        if (!pok)                               cause = 1;
        else if (va < lo || va + bytes > hi)    cause = 2;
        else if (sum >= (longint'(1) << 14))    cause = 3;
        else                                    cause = 0;
        pa = (cause != 0) ? 0 : ((sum << 30) | (va & ((longint'(1) << 30) - 1)));
    endfunction

    task automatic cycle_chk(input string note);
        #1;
        if (!rst) begin
            chk({note, " R8 tlb_req_valid"}, tlb_req_valid, req_valid && !req_xoff_vld);
            if (req_valid && !req_xoff_vld) begin
                chk({note, " R8 tlb_req_vaddr"}, tlb_req_vaddr, req_vaddr);
                chk({note, " R8 tlb_req_op"}, tlb_req_op, req_op);
                chk({note, " R8 tlb_req_size"}, tlb_req_size, req_size);
                chk({note, " R8 req_ready"}, req_ready, tlb_req_ready);
            end
            if (req_xoff_vld)
                chk({note, " R9 req_ready"}, req_ready, 1);
        end
        @(posedge clk);
        if (rst) begin
            e_rv = 0;
            e_fl = 0;
        end else begin
            e_rv = req_valid && req_xoff_vld;
            if (e_rv)
                ref_xlate(longint'(req_vaddr), int'(req_op), int'(req_size), int'(req_perm),
                          longint'(req_lo), longint'(req_hi), int'(req_xoff), e_cause, e_pa);
            e_fl = fence_valid && !fence_xoff_vld;
        end
        @(negedge clk);
        chk({note, " R1/R2 rsp_valid"}, rsp_valid, e_rv);
        chk({note, " R10 tlb_flush"}, tlb_flush, e_fl);
        if (e_rv) begin
            chk({note, " R7 rsp_cause"}, rsp_cause, e_cause);
            chk({note, " R7 rsp_exc"}, rsp_exc, e_cause != 0);
            chk({note, " R3 rsp_paddr"}, rsp_paddr, e_pa);
        end
    endtask

    task automatic drive(input longint va, input int op, input int sz, input int perm,
                         input longint lo, input longint hi, input int off, input bit offv);
        req_valid    = 1;
        req_vaddr    = VA_W'(va);
        req_op       = 2'(op);
        req_size     = 2'(sz);
        req_perm     = 3'(perm);
        req_lo       = BND_W'(lo);
        req_hi       = BND_W'(hi);
        req_xoff     = 16'(off);
        req_xoff_vld = offv;
    endtask

    task automatic idle();
        req_valid = 0; req_xoff_vld = 0; fence_valid = 0; fence_xoff_vld = 0;
    endtask

    localparam longint FULL_HI = longint'(1) << 39;

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog R2 act=running exp=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1; tlb_req_ready = 0;
        req_vaddr = '0; req_op = '0; req_size = '0; req_perm = '0;
        req_lo = '0; req_hi = '0; req_xoff = '0;
        idle();
        drive(64'h12_3456_7890, 0, 0, 7, 0, FULL_HI, 5, 1);
        fence_valid = 1;
        repeat (3) cycle_chk("R1 reset");
        @(negedge clk);
        rst = 0; idle();
        cycle_chk("R1 after reset");

        // R2 / R3 basic translations
        drive((longint'(5) << 30) | 64'h1234_5678, 0, 3, 1, 0, FULL_HI, 100, 1);
        cycle_chk("R2 vpn5+100");
        drive((longint'(0) << 30) | 64'h3fff_fff8, 1, 3, 2, 0, FULL_HI, 0, 1);
        cycle_chk("R3 zero offset");
        drive((longint'(300) << 30) | 64'h0000_0abc, 2, 2, 4, 0, FULL_HI, 16'hffff - 16'hc000, 1);
        cycle_chk("R2 fetch mid");
        // R6 overflow edge
        drive((longint'(511) << 30) | 64'h10, 0, 0, 1, 0, FULL_HI, 15872, 1);
        cycle_chk("R6 sum 16383");
        drive((longint'(511) << 30) | 64'h10, 0, 0, 1, 0, FULL_HI, 15873, 1);
        cycle_chk("R6 sum 16384");
        drive(64'h20, 0, 0, 1, 0, FULL_HI, 65535, 1);
        cycle_chk("R6 max offset");
        // R4 span edges
        drive(64'h1000, 0, 3, 1, 64'h1000, 64'h1008, 1, 1); cycle_chk("R4 exact fit");
        drive(64'h1001, 0, 3, 1, 64'h1000, 64'h1008, 1, 1); cycle_chk("R4 one past");
        drive(64'h0fff, 0, 0, 1, 64'h1000, 64'h1008, 1, 1); cycle_chk("R4 below lo");
        drive(64'h1007, 0, 0, 1, 64'h1000, 64'h1008, 1, 1); cycle_chk("R4 last byte");
        drive(64'h1006, 1, 1, 2, 64'h1000, 64'h1008, 1, 1); cycle_chk("R4 half at end");
        drive(64'h1006, 1, 2, 2, 64'h1000, 64'h1008, 1, 1); cycle_chk("R4 word over end");
        drive(64'h7f_ffff_fff8, 0, 3, 1, 0, FULL_HI, 0, 1);  cycle_chk("R4 top of space");
        // R5 permissions
        drive(64'h40, 1, 0, 1, 0, FULL_HI, 0, 1); cycle_chk("R5 store read-only");
        drive(64'h40, 2, 0, 3, 0, FULL_HI, 0, 1); cycle_chk("R5 fetch no exec");
        drive(64'h40, 2, 0, 4, 0, FULL_HI, 0, 1); cycle_chk("R5 fetch exec");
        drive(64'h40, 0, 0, 6, 0, FULL_HI, 0, 1); cycle_chk("R5 load no read");
        drive(64'h40, 3, 0, 7, 0, FULL_HI, 0, 1); cycle_chk("R5 reserved op");
        // R7 priority
        drive(64'h40, 1, 0, 1, 64'h100, 64'h200, 0, 1); cycle_chk("R7 perm over bounds");
        drive((longint'(511) << 30), 0, 0, 1, 0, 64'h10, 65535, 1); cycle_chk("R7 bounds over ovf");
        drive((longint'(511) << 30), 1, 0, 1, 0, 64'h10, 65535, 1); cycle_chk("R7 perm over all");
        // R8 legacy path with stall
        tlb_req_ready = 0;
        drive(64'h55_5555_5555, 1, 2, 0, 0, 0, 9, 0); cycle_chk("R8 stalled");
        cycle_chk("R8 still stalled");
        tlb_req_ready = 1; cycle_chk("R8 accepted");
        // R9 bypass ignores TLB ready
        tlb_req_ready = 0;
        drive(64'h40, 0, 0, 1, 0, FULL_HI, 3, 1); cycle_chk("R9 bypass while tlb busy");
        // R10 fences
        idle(); fence_valid = 1; fence_xoff_vld = 0; cycle_chk("R10 flush");
        fence_xoff_vld = 1; cycle_chk("R10 fence ignored");
        idle(); cycle_chk("R10 quiet");
        fence_valid = 1; fence_xoff_vld = 1; cycle_chk("R10 ignored alone");
        idle(); cycle_chk("R10 after ignored");

        // mixed stream
        for (int i = 0; i < 400; i++) begin
            longint va  = ((longint'($urandom) << 32) | longint'($urandom)) & (FULL_HI - 1);
            longint lo  = va - longint'($urandom % 12);
            longint hi  = va + longint'($urandom % 12);
            if (lo < 0) lo = 0;
            drive(va, int'($urandom % 4), int'($urandom % 4), int'($urandom % 8),
                  lo, hi, int'($urandom % 65536), ($urandom % 3) != 0);
            if ($urandom % 4 == 0) req_valid = 0;
            tlb_req_ready  = ($urandom % 2) != 0;
            fence_valid    = ($urandom % 3) == 0;
            fence_xoff_vld = ($urandom % 2) != 0;
            cycle_chk("R2 stream");
        end
        idle();
        cycle_chk("R2 drain");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule